// File: doc/BRIEF.md
# External Data Memory Stretch Controller

This block runs the bus side of a processor's external data memory access (read or write) and sets its length with a wait-state count that software can program. A cycle sequencer supplies a two-bit phase that steps through the four clocks of each instruction cycle. When the core asks for an access, the controller takes the request on the last phase of an instruction cycle and latches the address, the direction and the write data. It then drives the address and the strobes for a whole number of instruction cycles. It ends the access with a one-clock completion pulse, and on reads it returns the captured data with that pulse.

A special-function register holds the wait-state count. Its three low bits are the stretch value. Each unit of stretch adds one four-clock instruction cycle to the base length of two instruction cycles. Software may rewrite the register at any time. The value is latched when an access is accepted, so a rewrite only affects later accesses.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: The stretch register is eight bits wide and sits at special-function address 0x8E. It resets to 0x01. A write to that address is stored on the next clock edge. While `sfr_addr_i` equals 0x8E, `sfr_rdata_o` shows all eight stored bits; at any other address it shows 0.
- R2: Only register bits [2:0] set the stretch value s (0 to 7). Bits [7:3] have no effect on access timing.
- R3: A request is accepted at a clock edge where `req_i` is 1, `ph_i` equals 3 (the fourth phase), and the controller is idle or in the final clock of an access. The access then fills the next N = (2 + s) × 4 clocks, and `busy_o` is 1 in each of them. After an access with no new request, `busy_o` returns to 0.
- R4: Number the access clocks 1 to N, counting from the accept edge. `done_o` is a one-clock pulse in clock N and is 0 at every other time.
- R5: `mem_addr_o` holds the address latched at acceptance, and `addr_oe_o` is 1, in all clocks 1 to N. Later changes on the request inputs have no effect.
- R6: On a read (`req_we_i` = 0), `mem_rd_o` is 1 in clocks 5 to N-2 and 0 at all other times. `mem_wr_o` stays 0 and `data_oe_o` stays 0.
- R7: On a write (`req_we_i` = 1), `mem_wr_o` is 1 in clocks 5 to N-2 and `data_oe_o` is 1 in clocks 5 to N-1, with `mem_wdata_o` equal to the latched write data. `mem_rd_o` stays 0.
- R8: On a read, `rdata_o` takes the value that `mem_rdata_i` has in clock N-2, and shows it in clock N together with `done_o`. It keeps that value until the next read capture, so a write access leaves it unchanged.
- R9: The stretch value is taken from the register as it stands at the accept edge. A register write in the same clock as acceptance, or during the access, applies only to later accesses.
- R10: A request accepted in clock N of one access starts the next access at once: its clock 1 follows directly after the previous clock N.
- R11: A request raised while busy but not in the final clock, or while idle when `ph_i` is not 3, is ignored. It starts no access and changes no bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ph_i | input | 2 | Phase within the instruction cycle from the sequencer (0..3) |
| sfr_wr_i | input | 1 | Special-function register write strobe |
| sfr_addr_i | input | 8 | Special-function register address |
| sfr_wdata_i | input | 8 | Special-function register write data |
| sfr_rdata_o | output | 8 | Stretch register readback |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | Access direction: 1 write, 0 read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Access in progress |
| mem_addr_o | output | ADDR_W | Address to memory |
| addr_oe_o | output | 1 | Address bus enable |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DATA_W | Write data to memory |
| data_oe_o | output | 1 | Data bus drive enable |
| mem_rdata_i | input | DATA_W | Read data from memory |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | Access complete pulse |

## Verification
Two events can land on the same clock edge. First, software can rewrite the stretch register on the very edge that accepts a request. Second, a new request can be accepted on the final clock of the previous access. The bench sets up the first case by writing the register and raising a request together on a fourth phase. It then judges the access by its length, which must follow the old value, and by the length of the next access, which must follow the new one. It sets up the second case by raising the request in clock N. There it checks clock by clock that busy never drops and that the strobes of the second access start at its own clock 5.

// File: rtl/xms_pkg.sv
package xms_pkg;

    localparam int unsigned XMS_CLK_PER_ICYC = 4;

    typedef enum logic [1:0] {
        PH_C1 = 2'd0,
        PH_C2 = 2'd1,
        PH_C3 = 2'd2,
        PH_C4 = 2'd3
    } xms_phase_e;

endpackage

// File: rtl/xms_cfg_reg.sv
module xms_cfg_reg #(
    parameter logic [7:0] SFR_ADDR  = 8'h8E,
    parameter logic [7:0] RESET_VAL = 8'h01,
    parameter int unsigned STRETCH_W = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [7:0]           addr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    output logic [STRETCH_W-1:0] stretch_o
);

    typedef struct packed {
        logic [7:0] val;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = (addr_i == SFR_ADDR);
        st_d = st_q;
        if (wr_i && hit) begin
            st_d.val = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.val <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = hit ? st_q.val : 8'h00;
    assign stretch_o = st_q.val[STRETCH_W-1:0];

    // R1: a write to the register address is stored in full
    p_cfg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == SFR_ADDR) |=> (st_q.val == $past(wdata_i)));

    // R1: writes to other addresses leave the register alone
    p_cfg_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && addr_i == SFR_ADDR) |=> $stable(st_q.val));

endmodule

// File: rtl/xms_seq.sv
module xms_seq
    import xms_pkg::*;
#(
    parameter int unsigned STRETCH_W = 3,
    parameter int unsigned BASE_ICYC = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  xms_phase_e           ph_i,
    input  logic                 req_i,
    input  logic                 req_we_i,
    input  logic [STRETCH_W-1:0] stretch_i,
    output logic                 start_o,
    output logic                 busy_o,
    output logic                 addr_oe_o,
    output logic                 rd_stb_o,
    output logic                 wr_stb_o,
    output logic                 data_oe_o,
    output logic                 cap_o,
    output logic                 done_o
);

    localparam int unsigned MAX_STRETCH = (1 << STRETCH_W) - 1;
    localparam int unsigned MAX_CLKS    = (BASE_ICYC + MAX_STRETCH) * XMS_CLK_PER_ICYC;
    localparam int unsigned CNT_W       = $clog2(MAX_CLKS + 1);
    localparam int unsigned STB_FIRST   = XMS_CLK_PER_ICYC;

    typedef struct packed {
        logic             busy;
        logic             we;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic [CNT_W-1:0] last_calc;
    logic             final_clk;
    logic             start;
    logic             strobe_win;
    logic             drive_win;

    always_comb begin
        last_calc = CNT_W'((BASE_ICYC + int'(stretch_i)) * XMS_CLK_PER_ICYC - 1);
        final_clk = st_q.busy && (st_q.cnt == st_q.last);
        start     = req_i && (ph_i == PH_C4) && (!st_q.busy || final_clk);

        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.we   = req_we_i;
            st_d.cnt  = '0;
            st_d.last = last_calc;
        end else if (final_clk) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        strobe_win = st_q.busy && (st_q.cnt >= CNT_W'(STB_FIRST))
                     && (st_q.cnt <= st_q.last - CNT_W'(2));
        drive_win  = st_q.busy && (st_q.cnt >= CNT_W'(STB_FIRST))
                     && (st_q.cnt <= st_q.last - CNT_W'(1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.busy <= 1'b0;
            st_q.we   <= 1'b0;
            st_q.cnt  <= '0;
            st_q.last <= CNT_W'(BASE_ICYC * XMS_CLK_PER_ICYC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o   = start;
    assign busy_o    = st_q.busy;
    assign addr_oe_o = st_q.busy;
    assign rd_stb_o  = strobe_win && !st_q.we;
    assign wr_stb_o  = strobe_win && st_q.we;
    assign data_oe_o = drive_win && st_q.we;
    assign cap_o     = st_q.busy && !st_q.we && (st_q.cnt == st_q.last - CNT_W'(2));
    assign done_o    = final_clk;

    // R3: the clock count stays aligned with the sequencer phase
    p_phase_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.cnt[1:0] == 2'(ph_i)));

    // R4: the count never runs past the latched end
    p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.cnt <= st_q.last));

    // R4: completion is a single-clock pulse
    p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: the latched length holds unless a new access is accepted
    p_len_latched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start |=> $stable(st_q.last));

    // R11: a busy non-final clock always advances the count
    p_busy_advance_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !final_clk) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // R10: accept on the final clock restarts the count with no gap
    p_chain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (final_clk && start) |=> (st_q.busy && st_q.cnt == '0));

    // R6: read and write strobes never overlap
    p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_stb_o && wr_stb_o));

endmodule

// File: rtl/xms_dp.sv
module xms_dp #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_state_t;

    dp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.addr  = req_addr_i;
            st_d.wdata = req_wdata_i;
        end
        if (cap_i) begin
            st_d.rdata = mem_rdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign rdata_o = st_q.rdata;

    // R8: captured read data holds between captures
    p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_i |=> $stable(st_q.rdata));

    // R5: the address only changes on acceptance
    p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(st_q.addr));

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
    import xms_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned STRETCH_W = 3,
    parameter int unsigned BASE_ICYC = 2,
    parameter logic [7:0]  SFR_ADDR  = 8'h8E,
    parameter logic [7:0]  CFG_RESET = 8'h01
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        ph_i,
    input  logic              sfr_wr_i,
    input  logic [7:0]        sfr_addr_i,
    input  logic [7:0]        sfr_wdata_i,
    output logic [7:0]        sfr_rdata_o,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              addr_oe_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              data_oe_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);

    logic [STRETCH_W-1:0] stretch;
    logic                 start;
    logic                 cap;
    xms_phase_e           phase;

    assign phase = xms_phase_e'(ph_i);

    xms_cfg_reg #(
        .SFR_ADDR (SFR_ADDR),
        .RESET_VAL(CFG_RESET),
        .STRETCH_W(STRETCH_W)
    ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (sfr_wr_i),
        .addr_i   (sfr_addr_i),
        .wdata_i  (sfr_wdata_i),
        .rdata_o  (sfr_rdata_o),
        .stretch_o(stretch)
    );

    xms_seq #(
        .STRETCH_W(STRETCH_W),
        .BASE_ICYC(BASE_ICYC)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ph_i     (phase),
        .req_i    (req_i),
        .req_we_i (req_we_i),
        .stretch_i(stretch),
        .start_o  (start),
        .busy_o   (busy_o),
        .addr_oe_o(addr_oe_o),
        .rd_stb_o (mem_rd_o),
        .wr_stb_o (mem_wr_o),
        .data_oe_o(data_oe_o),
        .cap_o    (cap),
        .done_o   (done_o)
    );

    xms_dp #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start),
        .req_addr_i (req_addr_i),
        .req_wdata_i(req_wdata_i),
        .cap_i      (cap),
        .mem_rdata_i(mem_rdata_i),
        .addr_o     (mem_addr_o),
        .wdata_o    (mem_wdata_o),
        .rdata_o    (rdata_o)
    );

    // R7: the write strobe is always inside the data drive window
    p_wr_inside_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> data_oe_o);

    // R5: any strobe is inside the address enable window
    p_stb_inside_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o || mem_wr_o || done_o) |-> addr_oe_o);

endmodule

// File: tb/sim_xmem_stretch_ctrl.sv
module sim_xmem_stretch_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        ph;
    logic              sfr_wr;
    logic [7:0]        sfr_addr, sfr_wdata, sfr_rdata;
    logic              req, req_we;
    logic [ADDR_W-1:0] req_addr, mem_addr;
    logic [DATA_W-1:0] req_wdata, mem_wdata, mem_rdata, rdata;
    logic              busy, addr_oe, mem_rd, mem_wr, data_oe, done;

    int checks   = 0;
    int fails    = 0;
    bit finished = 1'b0;
    logic [7:0] last_rd = 8'h00;
    logic              nx_we;
    logic [ADDR_W-1:0] nx_a;
    logic [DATA_W-1:0] nx_wd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 2'd0;
        else        ph <= ph + 2'd1;
    end

    xmem_stretch_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .ph_i(ph),
        .sfr_wr_i(sfr_wr), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
        .sfr_rdata_o(sfr_rdata),
        .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .busy_o(busy), .mem_addr_o(mem_addr), .addr_oe_o(addr_oe),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
        .data_oe_o(data_oe), .mem_rdata_i(mem_rdata), .rdata_o(rdata), .done_o(done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input logic [15:0] a);
        return 8'(k * 13 + int'(a[7:0]));
    endfunction

    task automatic sfr_put(input logic [7:0] v);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = 8'h8E; sfr_wdata = v;
        @(negedge clk);
        sfr_wr = 1'b0;
        chk("R1 readback", sfr_rdata, v);
    endtask

    task automatic run(input int s, input bit we, input logic [15:0] a, input logic [7:0] wd,
                       input bit armed, input bit chain, input bit glitch,
                       input bit midwr, input logic [7:0] midval);
        int n;
        n = (2 + s) * 4;
        if (!armed) begin
            do @(negedge clk); while (ph != 2'd3);
            req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        end
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req = 1'b0; sfr_wr = 1'b0;
                req_addr = ~a; req_wdata = ~wd; req_we = ~we;
            end
            if (midwr && k == 3) begin
                sfr_wr = 1'b1; sfr_addr = 8'h8E; sfr_wdata = midval;
            end
            if (midwr && k == 4) sfr_wr = 1'b0;
            if (glitch && k == 4) begin req = 1'b1; req_addr = 16'hDEAD; end
            if (glitch && k == 5) req = 1'b0;
            chk("R3 busy in access", busy, 1);
            chk("R4 done pulse (R2 length)", done, (k == n));
            chk("R5 addr_oe", addr_oe, 1);
            chk("R5 address held", mem_addr, a);
            chk("R6 read strobe", mem_rd, (!we && k >= 5 && k <= n - 2));
            chk("R7 write strobe", mem_wr, (we && k >= 5 && k <= n - 2));
            chk("R7 data_oe", data_oe, (we && k >= 5 && k <= n - 1));
            if (data_oe) chk("R7 write data", mem_wdata, wd);
            if (k == n) begin
                if (!we) last_rd = pat(n - 2, a);
                chk("R8 read data at done", rdata, last_rd);
            end
            mem_rdata = pat(k, a);
            if (k == n && chain) begin
                req = 1'b1; req_we = nx_we; req_addr = nx_a; req_wdata = nx_wd;
            end
        end
        if (!chain) begin
            @(negedge clk);
            chk("R11 idle after access", busy, 0);
            chk("R3 no strobes when idle", {mem_rd, mem_wr, data_oe, addr_oe}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sfr_wr = 1'b0; sfr_addr = 8'h8E; sfr_wdata = 8'h00;
        req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
        nx_we = 1'b0; nx_a = '0; nx_wd = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset value", sfr_rdata, 8'h01);
        chk("R3 reset idle", {busy, done, mem_rd, mem_wr, data_oe}, 0);
        chk("R8 reset rdata", rdata, 0);
        sfr_addr = 8'h8F;
        @(negedge clk);
        chk("R1 other address reads zero", sfr_rdata, 0);
        sfr_addr = 8'h8E;
        rst_n = 1'b1;

        // R2: reset stretch of 1 gives 12 clocks
        run(1, 1'b0, 16'h1234, 8'h00, 0, 0, 0, 0, 8'h00);

        // Sweep every stretch value in both directions with varied upper bits (R2)
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 2; w++) begin
                sfr_put({5'(s * 7 + w * 11 + 3), 3'(s)});
                run(s, w[0], 16'(16'h4100 + s * 37 + w), 8'(8'hA0 + s * 3 + w), 0, 0, 0, 0, 8'h00);
            end
        end

        // R11: request while idle on a phase other than 3 is ignored
        do @(negedge clk); while (ph != 2'd1);
        req = 1'b1; req_we = 1'b0; req_addr = 16'h0BAD;
        @(negedge clk);
        req = 1'b0;
        chk("R11 off-phase request ignored", busy, 0);
        @(negedge clk);
        chk("R11 off-phase request ignored later", {busy, addr_oe}, 0);

        // R9: write and accept in the same clock; old value governs
        sfr_put(8'h02);
        do @(negedge clk); while (ph != 2'd3);
        sfr_wr = 1'b1; sfr_addr = 8'h8E; sfr_wdata = 8'h06;
        req = 1'b1; req_we = 1'b0; req_addr = 16'h2200; req_wdata = 8'h00;
        run(2, 1'b0, 16'h2200, 8'h00, 1, 0, 0, 0, 8'h00);
        chk("R9 same-clock write stored", sfr_rdata, 8'h06);
        run(6, 1'b1, 16'h2201, 8'h5A, 0, 0, 0, 0, 8'h00);

        // R9: write in mid-access does not change that access
        run(6, 1'b0, 16'h3300, 8'h00, 0, 0, 0, 1, 8'h00);
        run(0, 1'b0, 16'h3301, 8'h00, 0, 0, 0, 0, 8'h00);

        // R11: request while busy is ignored
        sfr_put(8'h03);
        run(3, 1'b1, 16'h4400, 8'hC3, 0, 0, 1, 0, 8'h00);

        // R10: back-to-back accesses
        sfr_put(8'hF8);
        nx_we = 1'b1; nx_a = 16'h5501; nx_wd = 8'h3C;
        run(0, 1'b0, 16'h5500, 8'h00, 0, 1, 0, 0, 8'h00);
        nx_we = 1'b0; nx_a = 16'h5502; nx_wd = 8'h00;
        run(0, 1'b1, 16'h5501, 8'h3C, 1, 1, 0, 0, 8'h00);
        run(0, 1'b0, 16'h5502, 8'h00, 1, 0, 0, 0, 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule